// File: doc/BRIEF.md
# DMA Channel Completion and Fault Interrupt Controller

This block gathers per-channel completion and error events from a multi-channel DMA engine into two 32-bit status words and drives a single interrupt line. The completion word carries one done flag per channel in its low half and one interrupt enable per channel in its high half. The error word carries one error flag per channel in its low half and, in its high half, a per-channel type bit. A set type bit marks a bus error. A clear type bit marks a termination error.

Software reaches each word through three addresses: a plain write, an OR-in alias and a write-one-to-clear alias. The block decides which errors are real faults. A termination error that lands on a channel whose completion flag is also set is treated as an ordinary finish. The block then exposes the highest pending event from a combined word that ranks faults above completions. When the handler acknowledges a pending fault, the block issues a one-cycle reset pulse to the faulted channel.

The event inputs and the service acknowledge are plain pulse pins with no back-pressure. An event cannot be refused, so the block never stalls its source: every event is absorbed in the cycle it arrives.

Top module: `dma_status_irq`

## Requirements
- R1: After reset both status words read as zero, `irq` is low, `pend_any` is low and `chan_rst` is zero.
- R2: Address bits [4] select the word (0 = completion, 1 = error) and bits [3:2] select the access (0 = plain write, 1 = OR-in, 2 = write-one-to-clear, 3 = unmapped and reads zero). A plain write replaces the whole word, and reading any of the three mapped addresses returns that word.
- R3: A write to the OR-in alias sets exactly the written one bits and leaves the other bits unchanged.
- R4: A write to the clear alias clears exactly the written one bits and leaves the other bits unchanged.
- R5: A pulse on `cmpl_evt[c]` sets completion bit c on the next clock. This holds even when a clear write to that bit happens in the same cycle.
- R6: A pulse on `err_evt[c]` sets error bit c. If `err_bus[c]` is high in the same cycle, it also sets type bit 16+c. `err_bus` with no `err_evt` has no effect.
- R7: A channel with both its error flag and its type bit set is faulted.
- R8: A channel with its error flag set and its type bit clear is faulted only when its completion flag is clear. If the completion flag is set, the channel is not faulted.
- R9: `irq` is high exactly when some completion flag has its enable set, or when some channel is faulted.
- R10: The combined word places the fault vector in bits 31:16 and the completion flags in bits 15:0. `pend_idx` is the index of its highest set bit, `pend_any` is high when the word is nonzero, and `pend_fault` is high when that index is 16 or above.
- R11: When `svc_ack` is high while `pend_fault` is high, `chan_rst` carries a one-cycle one-hot pulse on the faulted channel's bit on the next clock. Otherwise `chan_rst` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| cmpl_evt | input | 16 | Per-channel completion pulses |
| err_evt | input | 16 | Per-channel error pulses |
| err_bus | input | 16 | Error type qualifier, high for a bus error |
| svc_ack | input | 1 | Handler services the pending event |
| irq | output | 1 | Interrupt request |
| pend_any | output | 1 | Some event is pending |
| pend_idx | output | 5 | Highest pending bit of the combined word |
| pend_fault | output | 1 | Highest pending event is a fault |
| chan_rst | output | 16 | One-cycle per-channel reset pulse |

## Verification
A flag that is lost or stuck shows up at once in the register readback. It also shows up in the same cycle at `irq` and `pend_idx`, because both decode the stored words with no further registers. A wrong qualification of termination errors shows in `pend_fault` and `irq` right after the event cycle. It also shows one clock after an acknowledge, as a missing or misplaced `chan_rst` pulse. The sweep drives every channel through every mix of completion, error and type inputs, with and without the enable. Further cases cover priority between channels and a clear that collides with an event.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } reg_op_e;

  localparam logic SEL_CMPL = 1'b0;
  localparam logic SEL_ERR  = 1'b1;
endpackage

// File: rtl/dstat_reg.sv
module dstat_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_base,
  input  logic         we_set,
  input  logic         we_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt_set,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (we_base) nxt = wdata;
    if (we_set)  nxt = nxt | wdata;
    if (we_clr)  nxt = nxt & ~wdata;
    // hardware events are applied last so a colliding clear never drops one
    nxt = nxt | evt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/dstat_fault_qual.sv
module dstat_fault_qual #(
  parameter int NCH = 16
) (
  input  logic [2*NCH-1:0] err_word,
  input  logic [NCH-1:0]   done_flag,
  output logic [NCH-1:0]   fault
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic flag, bus;
    assign flag = err_word[c];
    assign bus  = err_word[NCH+c];
    assign fault[c] = (flag & bus) | (flag & ~bus & ~done_flag[c]);
  end
endmodule

// File: rtl/dstat_prio.sv
module dstat_prio #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/dma_status_irq.sv
module dma_status_irq
  import dma_stat_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 5,
  localparam int DW = 2 * NCH,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [NCH-1:0] cmpl_evt,
  input  logic [NCH-1:0] err_evt,
  input  logic [NCH-1:0] err_bus,
  input  logic          svc_ack,
  output logic          irq,
  output logic          pend_any,
  output logic [IW-1:0] pend_idx,
  output logic          pend_fault,
  output logic [NCH-1:0] chan_rst
);
  reg_op_e       w_op, r_op;
  logic          w_sel, r_sel;
  logic [DW-1:0] cmpl_q, err_q;
  logic [NCH-1:0] fault_vec;
  logic [DW-1:0] combined;
  logic [IW-1:0] fault_ch;

  assign w_op  = reg_op_e'(wr_addr[3:2]);
  assign w_sel = wr_addr[4];
  assign r_op  = reg_op_e'(rd_addr[3:2]);
  assign r_sel = rd_addr[4];

  dstat_reg #(.W(DW)) u_cmpl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_base (wr_en && w_sel == SEL_CMPL && w_op == OP_WRITE),
    .we_set  (wr_en && w_sel == SEL_CMPL && w_op == OP_SET),
    .we_clr  (wr_en && w_sel == SEL_CMPL && w_op == OP_CLR),
    .wdata   (wr_data),
    .evt_set ({{NCH{1'b0}}, cmpl_evt}),
    .q       (cmpl_q)
  );

  dstat_reg #(.W(DW)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_base (wr_en && w_sel == SEL_ERR && w_op == OP_WRITE),
    .we_set  (wr_en && w_sel == SEL_ERR && w_op == OP_SET),
    .we_clr  (wr_en && w_sel == SEL_ERR && w_op == OP_CLR),
    .wdata   (wr_data),
    .evt_set ({err_evt & err_bus, err_evt}),
    .q       (err_q)
  );

  dstat_fault_qual #(.NCH(NCH)) u_qual (
    .err_word  (err_q),
    .done_flag (cmpl_q[NCH-1:0]),
    .fault     (fault_vec)
  );

  assign combined = {fault_vec, cmpl_q[NCH-1:0]};

  dstat_prio #(.W(DW)) u_prio (
    .vec (combined),
    .any (pend_any),
    .idx (pend_idx)
  );

  assign pend_fault = pend_any && (pend_idx >= IW'(NCH));
  assign irq = (|(cmpl_q[NCH-1:0] & cmpl_q[DW-1:NCH])) || (|fault_vec);
  assign fault_ch = pend_idx - IW'(NCH);

  always_comb begin
    if (r_op == OP_NONE)        rd_data = '0;
    else if (r_sel == SEL_CMPL) rd_data = cmpl_q;
    else                        rd_data = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_rst <= '0;
    else if (svc_ack && pend_fault)
      chan_rst <= {{(NCH-1){1'b0}}, 1'b1} << fault_ch;
    else chan_rst <= '0;
  end
endmodule

// File: rtl/dma_status_irq_chk.sv
module dma_status_irq_chk #(
  parameter int NCH = 16,
  localparam int DW = 2 * NCH,
  localparam int IW = $clog2(DW)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] cmpl_evt,
  input logic           svc_ack,
  input logic           irq,
  input logic           pend_fault,
  input logic [NCH-1:0] chan_rst,
  input logic [DW-1:0]  cmpl_q,
  input logic [DW-1:0]  err_q,
  input logic [NCH-1:0] fault_vec
);
  p_rst_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_rst));

  p_rst_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && pend_fault) |=> (chan_rst != '0));

  p_rst_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc_ack && pend_fault) |=> (chan_rst == '0));

  p_evt_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmpl_evt) |=> ((cmpl_q[NCH-1:0] & $past(cmpl_evt)) == $past(cmpl_evt)));

  p_fault_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_vec) |-> irq);

  p_fault_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_vec) |-> pend_fault);

  always @(posedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (err_q[c] && !err_q[NCH+c] && cmpl_q[c])
          p_term_done_r8: assert (!fault_vec[c]);
      end
    end
  end
endmodule

bind dma_status_irq dma_status_irq_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmpl_evt   (cmpl_evt),
  .svc_ack    (svc_ack),
  .irq        (irq),
  .pend_fault (pend_fault),
  .chan_rst   (chan_rst),
  .cmpl_q     (cmpl_q),
  .err_q      (err_q),
  .fault_vec  (fault_vec)
);

// File: tb/tb_dma_status_irq.sv
module tb_dma_status_irq;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] cmpl_evt = '0, err_evt = '0, err_bus = '0;
  logic        svc_ack = 1'b0;
  logic        irq, pend_any, pend_fault;
  logic [4:0]  pend_idx;
  logic [15:0] chan_rst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_status_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmpl_evt(cmpl_evt), .err_evt(err_evt), .err_bus(err_bus),
    .svc_ack(svc_ack), .irq(irq), .pend_any(pend_any),
    .pend_idx(pend_idx), .pend_fault(pend_fault), .chan_rst(chan_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic evt(input logic [15:0] c, input logic [15:0] e, input logic [15:0] b);
    @(negedge clk);
    cmpl_evt = c; err_evt = e; err_bus = b;
    @(negedge clk);
    cmpl_evt = '0; err_evt = '0; err_bus = '0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(5'h00, v); chk("R1 cmpl", v, 0);
    rd(5'h10, v); chk("R1 err", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pend", {31'b0, pend_any}, 0);
    chk("R1 rst", {16'b0, chan_rst}, 0);
    rst_n = 1'b1;

    // R2 map and aliases
    wr(5'h00, 32'h1234_0000);
    rd(5'h00, v); chk("R2 base", v, 32'h1234_0000);
    rd(5'h04, v); chk("R2 set alias read", v, 32'h1234_0000);
    rd(5'h08, v); chk("R2 clr alias read", v, 32'h1234_0000);
    rd(5'h0C, v); chk("R2 unmapped", v, 0);
    // R3 OR-in
    wr(5'h04, 32'h0001_0000);
    rd(5'h00, v); chk("R3 set", v, 32'h1235_0000);
    // R4 clear
    wr(5'h08, 32'h0204_0000);
    rd(5'h00, v); chk("R4 clr", v, 32'h1031_0000);
    wr(5'h08, 32'hFFFF_FFFF);
    // R5 collision of clear and event
    evt(16'h0020, 0, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'h08; wr_data = 32'h0000_0030; cmpl_evt = 16'h0020;
    @(negedge clk);
    wr_en = 1'b0; cmpl_evt = '0;
    rd(5'h00, v); chk("R5 evt beats clear", v, 32'h0000_0020);
    wr(5'h08, 32'hFFFF_FFFF);

    // near-exhaustive sweep: every channel, every mix of inputs
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 8; m++) begin
        logic c, e, b, en, flt;
        c = m[0]; e = m[1]; b = m[2]; en = ((ch + m) % 2) == 1;
        flt = e && (b || !c);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        if (en) wr(5'h04, 32'h1 << (16 + ch));
        evt(16'(c) << ch, 16'(e) << ch, 16'(b) << ch);
        rd(5'h00, v); chk("R5 cmpl flag", v, (32'(en) << (16 + ch)) | (32'(c) << ch));
        rd(5'h10, v); chk("R6 err word", v, (32'(e) << ch) | (32'(e && b) << (16 + ch)));
        chk("R7 R8 fault", {31'b0, pend_fault}, {31'b0, flt});
        chk("R9 irq", {31'b0, irq}, {31'b0, (c && en) || flt});
        chk("R10 any", {31'b0, pend_any}, {31'b0, c || flt});
        if (c || flt) chk("R10 idx", {27'b0, pend_idx}, flt ? 16 + ch : ch);
        @(negedge clk); svc_ack = 1'b1;
        @(negedge clk); svc_ack = 1'b0;
        chk("R11 pulse", {16'b0, chan_rst}, flt ? (32'h1 << ch) : 0);
        @(negedge clk);
        chk("R11 one cycle", {16'b0, chan_rst}, 0);
      end
    end

    // R10 priority across channels
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    evt(16'h0208, 16'h0004, 0);
    chk("R10 fault above cmpl", {27'b0, pend_idx}, 18);
    wr(5'h18, 32'h0000_0004);
    chk("R10 highest cmpl", {27'b0, pend_idx}, 9);
    chk("R9 irq no enable", {31'b0, irq}, 0);
    evt(0, 16'h0800, 16'h0800);
    chk("R7 bus fault with cmpl", {27'b0, pend_idx}, 27);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule